// File: doc/BRIEF.md
# Memory Dependence Issue Scheduler

This block holds in-flight loads and stores between dispatch and issue. Each incoming instruction carries a sequence number, a load/store flag and a sequence number for a predicted producer store, which an outside predictor supplies. The block links the instruction to that store when the store is still held. An instruction may issue only when two conditions hold: its source registers are ready, and its predicted producer store has issued. Instructions that must run non-speculatively wait until an explicit release arrives.

The issue port always offers the oldest ready entry, which is the one with the smallest sequence number. When the consumer pops that entry and it is a store, every entry waiting on that store is woken in the same cycle by a broadcast compare of the store's sequence number. A squash removes every held entry younger than a given sequence number. Dependents of a squashed store are always younger than the store, so they go out with it. The pool has a fixed number of slots, and dispatch is refused while the pool is full.

Top module: `mds_sched`

## Requirements
- R1: After reset the pool is empty: `iss_valid` is 0 and `disp_ready` is 1.
- R2: An instruction dispatched with a producer field of zero, or one that names no held store, has no memory dependence. If its registers are ready it is offered on the issue port from the next cycle.
- R3: An instruction whose producer field names a held store is not offered for issue while that store is held.
- R4: A register-ready notification (`rr_valid`, `rr_seq`) makes a waiting entry issuable on the next cycle if its memory dependence is clear. Otherwise it only records register readiness, and the entry stays unissuable.
- R5: Popping a store wakes all of its dependents. Those whose registers are ready become issuable on the next cycle, and the others become issuable as soon as their register-ready notification arrives.
- R6: A popped entry leaves the pool on the next cycle. Popping a load wakes no other entry.
- R7: A non-speculative entry becomes issuable only on a release notification (`rel_valid`, `rel_seq`) that carries its sequence number. Register-ready notifications do not affect it.
- R8: While any entry is ready, the issue port presents the ready entry with the smallest sequence number, together with its store flag (1 = store).
- R9: A squash with value N removes every held entry whose sequence number is greater than N, whether it is waiting or ready, and keeps all others. A store removed this way is no longer a producer for later dispatches.
- R10: In a squash cycle, dispatch, pop, register-ready and release inputs have no effect.
- R11: With all DEPTH slots held, `disp_ready` is 0 and a dispatch attempt inserts nothing.
- R12: A register-ready notification and the wakeup from its producer store's pop, arriving in the same cycle for the same entry, make that entry issuable on the next cycle.
- R13: A dispatch whose producer field names the store being popped in the same cycle carries no memory dependence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | A free slot exists |
| disp_seq | input | SEQ_W | Sequence number of the dispatched instruction |
| disp_is_store | input | 1 | 1 = store, 0 = load |
| disp_prod_seq | input | SEQ_W | Predicted producer store sequence number, 0 = none |
| disp_regs_rdy | input | 1 | Source registers already ready |
| disp_nonspec | input | 1 | Instruction must wait for an explicit release |
| rr_valid | input | 1 | Register-ready notification |
| rr_seq | input | SEQ_W | Sequence number for the register-ready notification |
| rel_valid | input | 1 | Non-speculative release notification |
| rel_seq | input | SEQ_W | Sequence number for the release |
| iss_valid | output | 1 | A ready entry is offered |
| iss_seq | output | SEQ_W | Sequence number of the offered entry |
| iss_is_store | output | 1 | Offered entry is a store |
| iss_pop | input | 1 | Consumer takes the offered entry |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Squash boundary; entries above it are removed |

## Verification
The register-ready notification for a dependent load and the pop of its producer store can land in the same cycle, and each sets only one of the two readiness flags. The bench drives both in one cycle on the same entry and expects that entry on the issue port in the very next cycle. The bench also provokes a squash together with a dispatch and with a pop, and expects the survivors to be unchanged. A per-cycle queue model judges every case.

// File: rtl/mds_pkg.sv
package mds_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   // Per-slot status flags
   typedef struct packed {
      logic valid;
      logic nonspec;
      logic is_store;
      logic regs_rdy;
      logic md_rdy;
      logic in_rdy;
   } slot_flags_t;
endpackage

// File: rtl/mds_pick_free.sv
module mds_pick_free #(
   parameter int DEPTH = 16,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0] busy,
   output logic             any_free,
   output logic [IDX_W-1:0] free_idx
);
   timeunit 1ns;
   timeprecision 1ps;

   always_comb begin
      any_free = 1'b0;
      free_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (!busy[i]) begin
            any_free = 1'b1;
            free_idx = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/mds_oldest.sv
module mds_oldest #(
   parameter int DEPTH = 16,
   parameter int SEQ_W = 16,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0] rdy,
   input  logic [SEQ_W-1:0] seq_a [DEPTH],
   output logic             sel_vld,
   output logic [IDX_W-1:0] sel_idx
);
   timeunit 1ns;
   timeprecision 1ps;

   logic [SEQ_W-1:0] best;

   always_comb begin
      sel_vld = 1'b0;
      sel_idx = '0;
      best    = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (rdy[i] && (!sel_vld || seq_a[i] < best)) begin
            sel_vld = 1'b1;
            sel_idx = IDX_W'(i);
            best    = seq_a[i];
         end
      end
   end
endmodule

// File: rtl/mds_slot.sv
module mds_slot
   import mds_pkg::*;
#(
   parameter int SEQ_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sq_vld,
   input  logic [SEQ_W-1:0] sq_seq,
   input  logic             wr_en,
   input  slot_flags_t      wr_flags,
   input  logic [SEQ_W-1:0] wr_seq,
   input  logic [SEQ_W-1:0] wr_prod,
   input  logic             pop_me,
   input  logic             wake_vld,
   input  logic [SEQ_W-1:0] wake_seq,
   input  logic             rr_vld,
   input  logic [SEQ_W-1:0] rr_seq,
   input  logic             rel_vld,
   input  logic [SEQ_W-1:0] rel_seq,
   output slot_flags_t      flags,
   output logic [SEQ_W-1:0] seq
);
   timeunit 1ns;
   timeprecision 1ps;

   logic [SEQ_W-1:0] prod_q;
   slot_flags_t      nxt;
   logic             rr_hit, wake_hit, rel_hit;

   always_comb begin
      rr_hit   = rr_vld && (rr_seq == seq);
      wake_hit = wake_vld && !flags.md_rdy && (prod_q == wake_seq);
      rel_hit  = rel_vld && (rel_seq == seq);
      nxt          = flags;
      nxt.regs_rdy = flags.regs_rdy | rr_hit;
      nxt.md_rdy   = flags.md_rdy | wake_hit;
      if (flags.nonspec) begin
         if (rel_hit) nxt.in_rdy = 1'b1;
      end else if (nxt.regs_rdy && nxt.md_rdy) begin
         nxt.in_rdy = 1'b1;
      end
      if (pop_me || !flags.valid) nxt = '0;
      if (wr_en) nxt = wr_flags;
      if (sq_vld) nxt = (flags.valid && (seq > sq_seq)) ? '0 : flags;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags  <= '0;
         seq    <= '0;
         prod_q <= '0;
      end else begin
         flags <= nxt;
         if (wr_en && !sq_vld) begin
            seq    <= wr_seq;
            prod_q <= wr_prod;
         end
      end
   end
endmodule

// File: rtl/mds_sched.sv
module mds_sched
   import mds_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int SEQ_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             disp_valid,
   output logic             disp_ready,
   input  logic [SEQ_W-1:0] disp_seq,
   input  logic             disp_is_store,
   input  logic [SEQ_W-1:0] disp_prod_seq,
   input  logic             disp_regs_rdy,
   input  logic             disp_nonspec,
   input  logic             rr_valid,
   input  logic [SEQ_W-1:0] rr_seq,
   input  logic             rel_valid,
   input  logic [SEQ_W-1:0] rel_seq,
   output logic             iss_valid,
   output logic [SEQ_W-1:0] iss_seq,
   output logic             iss_is_store,
   input  logic             iss_pop,
   input  logic             sq_valid,
   input  logic [SEQ_W-1:0] sq_seq
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int IDX_W = $clog2(DEPTH);

   if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
      $error("mds_sched: DEPTH must be a power of two, at least 2");
   end
   if (SEQ_W < 2) begin : g_bad_seq
      $error("mds_sched: SEQ_W must be at least 2");
   end

   slot_flags_t      fl    [DEPTH];
   logic [SEQ_W-1:0] seq_a [DEPTH];
   logic [DEPTH-1:0] valid_v, rdy_v, ns_v, store_hit_v;
   logic             any_free, pop_fire, dep_hit, take;
   logic [IDX_W-1:0] free_idx, iss_idx;
   slot_flags_t      new_flags;

   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         valid_v[i]     = fl[i].valid;
         rdy_v[i]       = fl[i].valid && fl[i].in_rdy;
         ns_v[i]        = fl[i].valid && fl[i].nonspec;
         store_hit_v[i] = fl[i].valid && fl[i].is_store && (seq_a[i] == disp_prod_seq)
                          && !(pop_fire && (iss_idx == IDX_W'(i)));
      end
   end

   mds_pick_free #(.DEPTH(DEPTH)) u_free (
      .busy     (valid_v),
      .any_free (any_free),
      .free_idx (free_idx)
   );

   mds_oldest #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_oldest (
      .rdy     (rdy_v),
      .seq_a   (seq_a),
      .sel_vld (iss_valid),
      .sel_idx (iss_idx)
   );

   assign disp_ready   = any_free;
   assign iss_seq      = seq_a[iss_idx];
   assign iss_is_store = fl[iss_idx].is_store;
   assign pop_fire     = iss_pop && iss_valid && !sq_valid;
   assign take         = disp_valid && any_free && !sq_valid;
   assign dep_hit      = (disp_prod_seq != '0) && (|store_hit_v) && !disp_nonspec;

   always_comb begin
      new_flags          = '0;
      new_flags.valid    = 1'b1;
      new_flags.nonspec  = disp_nonspec;
      new_flags.is_store = disp_is_store;
      new_flags.regs_rdy = disp_regs_rdy;
      new_flags.md_rdy   = !dep_hit;
      new_flags.in_rdy   = !disp_nonspec && disp_regs_rdy && !dep_hit;
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      mds_slot #(.SEQ_W(SEQ_W)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .sq_vld   (sq_valid),
         .sq_seq   (sq_seq),
         .wr_en    (take && (free_idx == IDX_W'(g))),
         .wr_flags (new_flags),
         .wr_seq   (disp_seq),
         .wr_prod  (disp_prod_seq),
         .pop_me   (pop_fire && (iss_idx == IDX_W'(g))),
         .wake_vld (pop_fire && iss_is_store),
         .wake_seq (iss_seq),
         .rr_vld   (rr_valid),
         .rr_seq   (rr_seq),
         .rel_vld  (rel_valid),
         .rel_seq  (rel_seq),
         .flags    (fl[g]),
         .seq      (seq_a[g])
      );
   end
endmodule

// File: rtl/mds_sched_chk.sv
module mds_sched_chk #(
   parameter int DEPTH = 16,
   parameter int SEQ_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             disp_valid,
   input logic             disp_ready,
   input logic             sq_valid,
   input logic [SEQ_W-1:0] sq_seq,
   input logic             rel_valid,
   input logic             iss_valid,
   input logic [SEQ_W-1:0] iss_seq,
   input logic             iss_pop,
   input logic [DEPTH-1:0] valid_v,
   input logic [DEPTH-1:0] rdy_v,
   input logic [DEPTH-1:0] ns_v,
   input logic [SEQ_W-1:0] seq_a [DEPTH]
);
   timeunit 1ns;
   timeprecision 1ps;

   logic             last_sq;
   logic [SEQ_W-1:0] last_sq_seq;
   logic [DEPTH-1:0] younger, older;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_sq     <= 1'b0;
         last_sq_seq <= '0;
      end else begin
         last_sq     <= sq_valid;
         last_sq_seq <= sq_seq;
      end
   end

   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         younger[i] = valid_v[i] && (seq_a[i] > last_sq_seq);
         older[i]   = rdy_v[i] && (seq_a[i] < iss_seq);
      end
   end

   // R9
   squash_trim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last_sq |-> (younger == '0));

   // R8
   oldest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |-> (older == '0));

   // R6
   pop_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_pop && iss_valid && !sq_valid) |=> !(iss_valid && (iss_seq == $past(iss_seq))));

   // R7
   release_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(rdy_v & ~$past(rdy_v) & $past(ns_v))) |-> $past(rel_valid));

   // R11
   full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && !disp_ready) |=> ($countones(valid_v) <= $past($countones(valid_v))));

   // R11
   dispatch_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && disp_ready && !sq_valid && !(iss_pop && iss_valid))
      |=> ($countones(valid_v) == $past($countones(valid_v)) + 1));
endmodule

bind mds_sched mds_sched_chk #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .disp_valid (disp_valid),
   .disp_ready (disp_ready),
   .sq_valid   (sq_valid),
   .sq_seq     (sq_seq),
   .rel_valid  (rel_valid),
   .iss_valid  (iss_valid),
   .iss_seq    (iss_seq),
   .iss_pop    (iss_pop),
   .valid_v    (valid_v),
   .rdy_v      (rdy_v),
   .ns_v       (ns_v),
   .seq_a      (seq_a)
);

// File: tb/tb_mds_sched.sv
module tb_mds_sched;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int DEPTH = 16;
   localparam int SEQ_W = 16;

   logic clk = 1'b0;
   always #2 clk = ~clk;   // 4 ns period

   logic             rst_n = 1'b0;
   logic             disp_valid = 0, disp_is_store = 0, disp_regs_rdy = 0, disp_nonspec = 0;
   logic [SEQ_W-1:0] disp_seq = '0, disp_prod_seq = '0;
   logic             rr_valid = 0, rel_valid = 0, iss_pop = 0, sq_valid = 0;
   logic [SEQ_W-1:0] rr_seq = '0, rel_seq = '0, sq_seq = '0;
   logic             disp_ready, iss_valid, iss_is_store;
   logic [SEQ_W-1:0] iss_seq;

   mds_sched #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) dut (
      .clk(clk), .rst_n(rst_n),
      .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_seq(disp_seq),
      .disp_is_store(disp_is_store), .disp_prod_seq(disp_prod_seq),
      .disp_regs_rdy(disp_regs_rdy), .disp_nonspec(disp_nonspec),
      .rr_valid(rr_valid), .rr_seq(rr_seq), .rel_valid(rel_valid), .rel_seq(rel_seq),
      .iss_valid(iss_valid), .iss_seq(iss_seq), .iss_is_store(iss_is_store),
      .iss_pop(iss_pop), .sq_valid(sq_valid), .sq_seq(sq_seq)
   );

   typedef struct {
      int seq; int prod;
      bit st; bit ns; bit regs; bit md; bit rdy;
   } ment_t;

   ment_t mq[$];
   int    nchk = 0, nfail = 0;
   string cur_req = "R1";

   task automatic chk(bit ok, string what, int act, int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
      end
   endtask

   task automatic model_oldest(output bit v, output int s, output bit st);
      v = 0; s = 0; st = 0;
      foreach (mq[i]) if (mq[i].rdy && (!v || mq[i].seq < s)) begin
         v = 1; s = mq[i].seq; st = mq[i].st;
      end
   endtask

   task automatic model_step();
      bit pv, pst, pf, dep;
      int ps;
      bit can_disp;
      ment_t e;
      if (sq_valid) begin
         for (int i = mq.size() - 1; i >= 0; i--)
            if (mq[i].seq > int'(sq_seq)) mq.delete(i);
         return;
      end
      model_oldest(pv, ps, pst);
      pf  = iss_pop && pv;
      dep = 0;
      if (disp_prod_seq != 0 && !disp_nonspec)
         foreach (mq[i])
            if (mq[i].st && mq[i].seq == int'(disp_prod_seq) && !(pf && mq[i].seq == ps)) dep = 1;
      can_disp = disp_valid && (mq.size() < DEPTH);
      for (int i = mq.size() - 1; i >= 0; i--) begin
         if (pf && mq[i].seq == ps) begin
            mq.delete(i);
         end else begin
            if (rr_valid && mq[i].seq == int'(rr_seq)) mq[i].regs = 1;
            if (pf && pst && !mq[i].md && mq[i].prod == ps) mq[i].md = 1;
            if (mq[i].ns) begin
               if (rel_valid && mq[i].seq == int'(rel_seq)) mq[i].rdy = 1;
            end else if (mq[i].regs && mq[i].md) mq[i].rdy = 1;
         end
      end
      if (can_disp) begin
         e.seq = int'(disp_seq); e.prod = int'(disp_prod_seq);
         e.st = disp_is_store; e.ns = disp_nonspec; e.regs = disp_regs_rdy;
         e.md = disp_nonspec ? 1'b1 : !dep;
         e.rdy = !disp_nonspec && disp_regs_rdy && !dep;
         mq.push_back(e);
      end
   endtask

   task automatic compare();
      bit ev, est;
      int es;
      model_oldest(ev, es, est);
      chk(disp_ready == (mq.size() < DEPTH), "disp_ready", disp_ready, mq.size() < DEPTH);
      chk(iss_valid == ev, "iss_valid", iss_valid, ev);
      if (ev && iss_valid) begin
         chk(int'(iss_seq) == es, "iss_seq", iss_seq, es);
         chk(iss_is_store == est, "iss_is_store", iss_is_store, est);
      end
   endtask

   task automatic go();
      model_step();
      @(posedge clk);
      #1;
      compare();
      disp_valid = 0; rr_valid = 0; rel_valid = 0; iss_pop = 0; sq_valid = 0;
   endtask

   task automatic set_disp(int s, bit st, int p, bit r, bit ns);
      disp_valid = 1; disp_seq = SEQ_W'(s); disp_is_store = st;
      disp_prod_seq = SEQ_W'(p); disp_regs_rdy = r; disp_nonspec = ns;
   endtask

   task automatic dsp(int s, bit st, int p, bit r, bit ns);
      set_disp(s, st, p, r, ns); go();
   endtask
   task automatic pop();            iss_pop = 1; go(); endtask
   task automatic rr(int s);        rr_valid = 1; rr_seq = SEQ_W'(s); go(); endtask
   task automatic rel(int s);       rel_valid = 1; rel_seq = SEQ_W'(s); go(); endtask
   task automatic sq(int n);        sq_valid = 1; sq_seq = SEQ_W'(n); go(); endtask

   task automatic expect_iss(bit v, int s);
      chk(iss_valid == v, "directed iss_valid", iss_valid, v);
      if (v) chk(int'(iss_seq) == s, "directed iss_seq", iss_seq, s);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", 20000, 0);
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      cur_req = "R1";
      compare();
      chk(iss_valid == 1'b0, "reset iss_valid", iss_valid, 0);
      chk(disp_ready == 1'b1, "reset disp_ready", disp_ready, 1);

      cur_req = "R2";
      dsp(10, 0, 0, 1, 0);
      expect_iss(1, 10);
      dsp(11, 0, 99, 1, 0);
      pop(); expect_iss(1, 11);
      pop(); expect_iss(0, 0);

      cur_req = "R3";
      dsp(20, 1, 0, 1, 0);
      dsp(21, 0, 20, 1, 0);
      dsp(22, 0, 20, 0, 0);
      dsp(23, 0, 20, 1, 0);
      expect_iss(1, 20);
      cur_req = "R5";
      pop(); expect_iss(1, 21);
      pop(); expect_iss(1, 23);
      pop(); expect_iss(0, 0);
      cur_req = "R4";
      rr(22); expect_iss(1, 22);
      pop();
      dsp(30, 1, 0, 0, 0);
      rr(30); expect_iss(1, 30);
      pop();
      dsp(40, 1, 0, 1, 0);
      dsp(41, 0, 40, 0, 0);
      rr(41); expect_iss(1, 40);
      pop(); expect_iss(1, 41);
      pop();

      cur_req = "R6";
      dsp(55, 1, 0, 0, 0);
      dsp(56, 0, 55, 1, 0);
      dsp(57, 0, 0, 1, 0);
      pop(); expect_iss(0, 0);
      rr(55); expect_iss(1, 55);
      pop(); expect_iss(1, 56);
      pop(); expect_iss(0, 0);

      cur_req = "R7";
      dsp(60, 0, 0, 1, 1);
      expect_iss(0, 0);
      rr(60); expect_iss(0, 0);
      rel(60); expect_iss(1, 60);
      pop();
      dsp(61, 1, 0, 1, 1);
      dsp(62, 0, 61, 1, 0);
      rel(61); expect_iss(1, 61);
      pop(); expect_iss(1, 62);
      pop();

      cur_req = "R8";
      dsp(70, 1, 0, 0, 0);
      dsp(71, 0, 0, 1, 0);
      dsp(72, 1, 0, 1, 0);
      expect_iss(1, 71);
      rr(70); expect_iss(1, 70);
      pop(); pop(); expect_iss(1, 72);
      pop(); expect_iss(0, 0);

      cur_req = "R11";
      for (int k = 0; k < DEPTH; k++) dsp(100 + k, 0, 0, 0, 0);
      chk(disp_ready == 1'b0, "full disp_ready", disp_ready, 0);
      dsp(116, 0, 0, 1, 0);
      sq(120);
      chk(iss_valid == 1'b0, "ignored dispatch absent", iss_valid, 0);
      cur_req = "R9";
      sq(107);
      chk(disp_ready == 1'b1, "after squash disp_ready", disp_ready, 1);
      cur_req = "R10";
      sq_valid = 1; sq_seq = 200; set_disp(117, 0, 0, 1, 0); go();
      expect_iss(0, 0);
      rr(100); expect_iss(1, 100);
      sq_valid = 1; sq_seq = 200; iss_pop = 1; rr_valid = 1; rr_seq = 101; go();
      expect_iss(1, 100);
      cur_req = "R9";
      sq(99); expect_iss(0, 0);
      chk(disp_ready == 1'b1, "empty after squash", disp_ready, 1);

      cur_req = "R12";
      dsp(150, 1, 0, 1, 0);
      dsp(151, 0, 150, 0, 0);
      iss_pop = 1; rr_valid = 1; rr_seq = 151; go();
      expect_iss(1, 151);
      pop();

      cur_req = "R13";
      dsp(160, 1, 0, 1, 0);
      iss_pop = 1; set_disp(161, 0, 160, 1, 0); go();
      expect_iss(1, 161);
      pop();

      cur_req = "R9";
      dsp(170, 1, 0, 0, 0);
      dsp(171, 0, 170, 1, 0);
      dsp(172, 0, 170, 0, 0);
      sq(171);
      rr(170); pop(); expect_iss(1, 171);
      pop(); expect_iss(0, 0);
      dsp(180, 1, 0, 0, 0);
      sq(179);
      dsp(181, 0, 180, 1, 0);
      expect_iss(1, 181);
      pop(); expect_iss(0, 0);

      summary();
      $finish;
   end
endmodule